// File: doc/BRIEF.md
# Accumulator Barrel Shifter Unit

This unit shifts a 36-bit accumulator value. The value is a 32-bit word with a 4-bit guard field above it. Four kinds of shift are offered. The arithmetic right shift keeps the sign across the whole 36 bits. The logical right shift acts on the 32-bit word only. The arithmetic and logical left shifts both push word bits up into the guard field rather than sign-extending into it.

The shift distance arrives as a 16-bit operand. A source tag says where that operand came from: an immediate, an auxiliary register or a second accumulator. The tag changes only the latency. A request is sampled when its valid strobe is high and the unit is idle. The result is registered at that edge. A one-cycle done pulse marks the end of the modelled execution time.

Top module: `acc_shift_unit`

## Requirements
- R1: Kind code 2'b00 (arithmetic right) shifts all 36 bits right and fills the vacated upper positions with copies of bit 35.
- R2: Kind code 2'b01 (logical right) shifts bits 31:0 right with zero fill, and the result's bits 35:32 are always zero.
- R3: Kind codes 2'b10 (arithmetic left) and 2'b11 (logical left) give the same result. All 36 bits shift left with zeros entering at bit 0, bits leaving bit 31 land in bits 35:32, and bits above bit 35 are discarded.
- R4: The shift distance is bits 5:0 of the 16-bit amount operand, read as unsigned, and bits 15:6 have no effect. A distance of 36 or more gives all fill bits: copies of bit 35 for arithmetic right, zero for every other kind.
- R5: Source code 2'b01 (auxiliary register) completes in 1 cycle: `res_done` is high in the cycle that follows the accepting clock edge.
- R6: Source codes 2'b00 (immediate), 2'b10 (accumulator) and the spare code 2'b11 complete in 2 cycles: `res_done` is low in the cycle after the accepting edge and high in the cycle after that.
- R7: `res_done` is high for exactly one cycle per accepted request.
- R8: While a request is in flight, up to and including its done cycle, a new `req_valid` is ignored. It causes no extra done pulse and leaves `res_acc` unchanged.
- R9: `res_acc` is valid from the done cycle onward and is held until the next accepted request.
- R10: After reset, `res_done` is low and `res_acc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| req_valid | input | 1 | Request strobe, taken when the unit is idle |
| req_kind | input | 2 | Shift kind: 00 arithmetic right, 01 logical right, 10 arithmetic left, 11 logical left |
| req_src | input | 2 | Amount source: 00 immediate, 01 auxiliary register, 10 accumulator, 11 spare (2-cycle) |
| src_acc | input | 36 | Source accumulator, guard field in bits 35:32 |
| shamt_word | input | 16 | Shift amount operand; bits 5:0 are used |
| res_acc | output | 36 | Destination accumulator |
| res_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the request fields are stable during the cycle in which `req_valid` is sampled. They also assume that nothing outside the unit relies on `res_acc` before `res_done`. The bench changes inputs only on falling edges, so every sampled request is fully settled. Most requests are released after one cycle. Deliberate back-to-back traffic is confined to the in-flight rejection test, so every latency the assertions expect comes from a single accepted request.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  typedef enum logic [1:0] {
    SK_ASR = 2'b00,
    SK_LSR = 2'b01,
    SK_ASL = 2'b10,
    SK_LSL = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'b00,
    SRC_AUX = 2'b01,
    SRC_ACC = 2'b10,
    SRC_RSV = 2'b11
  } amt_src_e;

endpackage

// File: rtl/acc_shift_core.sv
module acc_shift_core
  import acc_shift_pkg::*;
#(
  parameter int GUARD_W = 4,
  parameter int WORD_W  = 32,
  parameter int AMT_W   = 6,
  localparam int ACC_W  = GUARD_W + WORD_W
) (
  input  shift_kind_e        kind,
  input  logic [ACC_W-1:0]   acc_in,
  input  logic [AMT_W-1:0]   amt,
  output logic [ACC_W-1:0]   acc_out
);

  logic              over_acc;
  logic              over_word;
  logic [WORD_W-1:0] word_sh;

  always_comb begin
    over_acc  = (int'(amt) >= ACC_W);
    over_word = (int'(amt) >= WORD_W);
    word_sh   = over_word ? '0 : (acc_in[WORD_W-1:0] >> amt);
    unique case (kind)
      SK_ASR:  acc_out = over_acc ? {ACC_W{acc_in[ACC_W-1]}}
                                  : ACC_W'($signed(acc_in) >>> amt);
      SK_LSR:  acc_out = {{GUARD_W{1'b0}}, word_sh};
      default: acc_out = over_acc ? '0 : (acc_in << amt);
    endcase
  end

endmodule

// File: rtl/acc_shift_seq.sv
module acc_shift_seq
  import acc_shift_pkg::*;
#(
  parameter int LAT_AUX   = 1,
  parameter int LAT_OTHER = 2,
  localparam int CNT_W    = $clog2(LAT_OTHER + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  amt_src_e req_src,
  output logic     accept,
  output logic     busy,
  output logic     done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lat;

  always_comb begin
    lat    = (req_src == SRC_AUX) ? CNT_W'(LAT_AUX) : CNT_W'(LAT_OTHER);
    busy   = (cnt_q != '0);
    accept = req_valid && !busy;
    done   = (cnt_q == CNT_W'(1));
    if (accept)    cnt_d = lat;
    else if (busy) cnt_d = cnt_q - CNT_W'(1);
    else           cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int GUARD_W = 4,
  parameter int WORD_W  = 32,
  parameter int OPND_W  = 16,
  parameter int AMT_W   = 6,
  localparam int ACC_W  = GUARD_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_src,
  input  logic [ACC_W-1:0]  src_acc,
  input  logic [OPND_W-1:0] shamt_word,
  output logic [ACC_W-1:0]  res_acc,
  output logic              res_done
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept_w;
  logic             busy_w;
  logic [ACC_W-1:0] shifted_w;
  logic [ACC_W-1:0] res_q;
  logic [ACC_W-1:0] res_d;
  logic             unused_hi;

  assign unused_hi = ^shamt_word[OPND_W-1:AMT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_shift_core #(
    .GUARD_W (GUARD_W),
    .WORD_W  (WORD_W),
    .AMT_W   (AMT_W)
  ) core_i (
    .kind    (shift_kind_e'(req_kind)),
    .acc_in  (src_acc),
    .amt     (shamt_word[AMT_W-1:0]),
    .acc_out (shifted_w)
  );

  acc_shift_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_src   (amt_src_e'(req_src)),
    .accept    (accept_w),
    .busy      (busy_w),
    .done      (res_done)
  );

  always_comb begin
    res_d = accept_w ? shifted_w : res_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) res_q <= '0;
    else            res_q <= res_d;
  end

  assign res_acc = res_q;

endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic [1:0]       req_kind,
  input logic [1:0]       req_src,
  input logic [ACC_W-1:0] res_acc,
  input logic             res_done
);

  // R5
  aux_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_src == 2'b01) |=> res_done);

  // R6
  slow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_src != 2'b01) |=> !res_done ##1 res_done);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(res_acc));

  // R2
  lsr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 2'b01) |=> (res_acc[ACC_W-1:ACC_W-4] == 4'h0));

endmodule

bind acc_shift_unit acc_shift_chk #(.ACC_W(ACC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .accept   (accept_w),
  .busy     (busy_w),
  .req_kind (req_kind),
  .req_src  (req_src),
  .res_acc  (res_acc),
  .res_done (res_done)
);

// File: tb/acc_shift_unit_tb.sv
module acc_shift_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [1:0]  req_src;
  logic [35:0] src_acc;
  logic [15:0] shamt_word;
  logic [35:0] res_acc;
  logic        res_done;

  int n_chk;
  int n_fail;

  acc_shift_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_src    (req_src),
    .src_acc    (src_acc),
    .shamt_word (shamt_word),
    .res_acc    (res_acc),
    .res_done   (res_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic [1:0] k, input logic [35:0] a,
                                        input logic [15:0] w);
    int s;
    logic [35:0] r;
    s = int'(w[5:0]);
    for (int i = 0; i < 36; i++) begin
      case (k)
        2'b00:   r[i] = (i + s < 36) ? a[i + s] : a[35];
        2'b01:   r[i] = (i < 32 && i + s < 32) ? a[i + s] : 1'b0;
        default: r[i] = (i >= s) ? a[i - s] : 1'b0;
      endcase
    end
    return r;
  endfunction

  // issue one request, wait for done, check latency, value and pulse width
  task automatic run_op(input logic [1:0] k, input logic [1:0] s,
                        input logic [35:0] a, input logic [15:0] w, input string req);
    int lat;
    logic [35:0] e;
    e = model(k, a, w);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_src = s; src_acc = a; shamt_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_done && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    // R5 / R6 latency by source
    check(lat == ((s == 2'b01) ? 1 : 2), (s == 2'b01) ? "R5" : "R6",
          36'(lat), (s == 2'b01) ? 36'd1 : 36'd2);
    check(res_acc === e, req, res_acc, e);
    @(negedge clk);
    // R7 single pulse, R9 result held
    check(!res_done, "R7", {35'd0, res_done}, 36'd0);
    check(res_acc === e, "R9", res_acc, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd1, 36'd0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [35:0] pats [4];
    logic [35:0] first_e;
    n_chk = 0; n_fail = 0;
    req_valid = 1'b0; req_kind = 2'b00; req_src = 2'b00;
    src_acc = '0; shamt_word = '0;
    rst_n = 1'b0;
    pats[0] = 36'h8_9ABC_DEF1;
    pats[1] = 36'h7_1234_5678;
    pats[2] = 36'h0_F000_0001;
    pats[3] = 36'hF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(res_done === 1'b0, "R10", {35'd0, res_done}, 36'd0);
    check(res_acc === 36'd0, "R10", res_acc, 36'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_acc === 36'd0 && res_done === 1'b0, "R10", res_acc, 36'd0);

    // sweep kind x distance x pattern, source rotating
    for (int k = 0; k < 4; k++)
      for (int d = 0; d <= 40; d++)
        for (int p = 0; p < 4; p++)
          run_op(2'(k), 2'((d + p + k) % 4), pats[p], 16'(d),
                 (k == 0) ? "R1" : (k == 1) ? "R2" : "R3");

    // R4 upper operand bits ignored, large distances fill
    for (int k = 0; k < 4; k++) begin
      run_op(2'(k), 2'b01, pats[0], 16'hFFC3, "R4");
      run_op(2'(k), 2'b00, pats[1], 16'h0040, "R4");
      run_op(2'(k), 2'b10, pats[0], 16'h003F, "R4");
      run_op(2'(k), 2'b11, pats[3], 16'hABE4, "R4");
    end

    // R8 requests during flight, including the done cycle, are ignored
    first_e = model(2'b00, pats[0], 16'd4);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_src = 2'b00;
    src_acc = pats[0]; shamt_word = 16'd4;
    @(negedge clk);
    req_kind = 2'b11; req_src = 2'b01; src_acc = pats[1]; shamt_word = 16'd1;
    check(!res_done, "R8", {35'd0, res_done}, 36'd0);
    @(negedge clk);
    check(res_done === 1'b1, "R8", {35'd0, res_done}, 36'd1);
    check(res_acc === first_e, "R8", res_acc, first_e);
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!res_done, "R8", {35'd0, res_done}, 36'd0);
      check(res_acc === first_e, "R8", res_acc, first_e);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule